// File: doc/BRIEF.md
# Interrupt Request and Enable Controller

This block collects interrupt events from eight sources of a small 4-bit processor core. The sources are external lines 0 and 1, four timers, the end of an analog-to-digital conversion and the serial port. Each source has a request flag that latches its event. Each source also has an enable bit. The enable bits sit in two 4-bit registers, which the core writes from its accumulator and reads back into it. A master enable gates the whole set. When a source is enabled, its flag is up and the master enable is on, the block raises an interrupt and presents a 3-bit source index, chosen by a fixed priority.

The core can also poll a source with a conditional-skip instruction. The poll is honoured only while that source's interrupt is disabled, so software cannot steal a request that the interrupt path is going to serve. Taking an interrupt and a successful poll both clear the flag they consume. The timers, the converter, the serial port and vector fetch are outside this block.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset both enable registers read 0000, the master enable is off, every request flag is 0, and `irq_o` and `skip_o` are 0.
- R2: A write strobe loads `acc_i` into the register picked by `en_sel_i`, and `en_rd_o` shows that register with no clock delay. The field layout is as follows. Select 0: bit 0 external 0 (source 0), bit 1 external 1 (source 1), bit 2 timer 1 (source 2), bit 3 timer 2 (source 3). Select 1: bit 0 timer 3 (source 4), bit 1 timer 4 (source 5), bit 2 conversion done (source 6), bit 3 serial port (source 7).
- R3: A low-power entry strobe clears both enable registers at the next edge, and it takes priority over a write in the same cycle.
- R4: An event pulse on `evt_i[k]` sets flag k at the next edge, whatever the master enable and the enable bit k are.
- R5: `irq_o` is 1 exactly when the master enable is on and some source has both its enable bit and its flag at 1. `irq_idx_o` then gives the lowest such source index.
- R6: At the edge that ends a cycle with `irq_o` at 1, the interrupt is accepted. The master enable turns off and only the flag of the indexed source is cleared.
- R7: With `tst_i` high, `skip_o` is 1 exactly when enable bit `tst_sel_i` is 0 and flag `tst_sel_i` is 1. A skip clears that flag at the next edge.
- R8: While enable bit k is 1, a test of source k gives `skip_o` = 0 and leaves flag k unchanged.
- R9: If an event on source k falls in the same cycle as a clear of flag k, by acceptance or by skip, the flag stays at 1.
- R10: `mie_set_i` turns the master enable on and `mie_clr_i` turns it off. When both are high in the same cycle, the clear wins, and so does an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lp_entry_i | input | 1 | Low-power entry strobe, clears both enable registers |
| en_wr_i | input | 1 | Enable register write strobe |
| en_sel_i | input | 1 | Enable register select, 0 or 1 |
| acc_i | input | 4 | Accumulator value to write |
| en_rd_o | output | 4 | Contents of the selected enable register |
| mie_set_i | input | 1 | Turn the master enable on |
| mie_clr_i | input | 1 | Turn the master enable off |
| evt_i | input | 8 | Per-source activation pulses |
| irq_o | output | 1 | Interrupt raised (accepted at the clock edge) |
| irq_idx_o | output | 3 | Index of the winning source |
| tst_i | input | 1 | Skip-test strobe |
| tst_sel_i | input | 3 | Source tested by the skip-test |
| skip_o | output | 1 | Skip-test result |

## Verification
Several assertions assume that the core never leaves `irq_o` unanswered. Any cycle with `irq_o` high is taken as an acceptance, so the master-enable and flag checks on the following cycle rely on the core consuming the interrupt at that edge. The flag-hold and flag-clear properties also assume that `tst_sel_i` is a stable, in-range index while `tst_i` is high. The stimulus meets these assumptions by keeping the master enable off while it loads flags. It then releases exactly one acceptance per trial and clears any leftover flags with skip polls only after the enables are off, so every source is tested under a known combination of master enable, enable bit and flag.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
   // source numbering, lowest number has highest priority
   localparam int SRC_EXT0  = 0;
   localparam int SRC_EXT1  = 1;
   localparam int SRC_TMR1  = 2;
   localparam int SRC_TMR2  = 3;
   localparam int SRC_TMR3  = 4;
   localparam int SRC_TMR4  = 5;
   localparam int SRC_ADC   = 6;
   localparam int SRC_SER   = 7;
   localparam int DEF_GRP_W   = 4;
   localparam int DEF_NUM_GRP = 2;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs #(
   parameter int GRP_W   = 4,
   parameter int NUM_GRP = 2,
   parameter int SEL_W   = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lp_entry_i,
   input  logic                       wr_i,
   input  logic [SEL_W-1:0]           sel_i,
   input  logic [GRP_W-1:0]           wdata_i,
   output logic [GRP_W-1:0]           rdata_o,
   output logic [NUM_GRP*GRP_W-1:0]   en_o
);
   logic [GRP_W-1:0] grp_q [NUM_GRP];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            grp_q[g] <= '0;
         else if (lp_entry_i)
            grp_q[g] <= '0;
         else if (wr_i && (int'(sel_i) == g))
            grp_q[g] <= wdata_i;
      end
      assign en_o[g*GRP_W +: GRP_W] = grp_q[g];
   end

   if (NUM_GRP == 1) begin : g_rd_single
      assign rdata_o = grp_q[0];
   end else begin : g_rd_multi
      always_comb begin
         rdata_o = '0;
         for (int g = 0; g < NUM_GRP; g++)
            if (int'(sel_i) == g) rdata_o = grp_q[g];
      end
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] flag_o
);
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_o[k] <= 1'b0;
         else if (set_i[k])
            flag_o[k] <= 1'b1;   // new event beats a clear
         else if (clr_i[k])
            flag_o[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               valid_o,
   output logic [IDX_W-1:0]   idx_o
);
   always_comb begin
      idx_o = '0;
      for (int k = NUM_SRC - 1; k >= 0; k--)
         if (req_i[k]) idx_o = IDX_W'(k);
   end
   assign valid_o = |req_i;
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
   import irq_req_pkg::*;
#(
   parameter int GRP_W   = DEF_GRP_W,
   parameter int NUM_GRP = DEF_NUM_GRP,
   localparam int NUM_SRC = GRP_W * NUM_GRP,
   localparam int IDX_W   = sel_width(NUM_SRC),
   localparam int SEL_W   = sel_width(NUM_GRP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lp_entry_i,
   input  logic               en_wr_i,
   input  logic [SEL_W-1:0]   en_sel_i,
   input  logic [GRP_W-1:0]   acc_i,
   output logic [GRP_W-1:0]   en_rd_o,
   input  logic               mie_set_i,
   input  logic               mie_clr_i,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic               irq_o,
   output logic [IDX_W-1:0]   irq_idx_o,
   input  logic               tst_i,
   input  logic [IDX_W-1:0]   tst_sel_i,
   output logic               skip_o
);
   if (GRP_W < 1) begin : g_bad_grp_w
      $error("irq_req_ctrl: GRP_W must be at least 1");
   end
   if (NUM_GRP < 1) begin : g_bad_num_grp
      $error("irq_req_ctrl: NUM_GRP must be at least 1");
   end
   if (NUM_SRC < 2) begin : g_bad_num_src
      $error("irq_req_ctrl: need at least two sources");
   end

   logic [NUM_SRC-1:0] en_vec;
   logic [NUM_SRC-1:0] flag_vec;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] clr_vec;
   logic               mie_q;
   logic               tst_en;
   logic               tst_flag;

   irq_en_regs #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP), .SEL_W(SEL_W)) i_en_regs (
      .clk(clk), .rst_n(rst_n), .lp_entry_i(lp_entry_i), .wr_i(en_wr_i),
      .sel_i(en_sel_i), .wdata_i(acc_i), .rdata_o(en_rd_o), .en_o(en_vec)
   );

   assign pend = en_vec & flag_vec & {NUM_SRC{mie_q}};

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_prio (
      .req_i(pend), .valid_o(irq_o), .idx_o(irq_idx_o)
   );

   always_comb begin
      tst_en   = 1'b0;
      tst_flag = 1'b0;
      for (int k = 0; k < NUM_SRC; k++)
         if (int'(tst_sel_i) == k) begin
            tst_en   = en_vec[k];
            tst_flag = flag_vec[k];
         end
   end

   assign skip_o = tst_i & ~tst_en & tst_flag;

   always_comb begin
      clr_vec = '0;
      if (irq_o)  clr_vec = clr_vec | (NUM_SRC'(1) << irq_idx_o);
      if (skip_o) clr_vec = clr_vec | (NUM_SRC'(1) << tst_sel_i);
   end

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) i_flags (
      .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_vec), .flag_o(flag_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mie_q <= 1'b0;
      else if (irq_o || mie_clr_i)
         mie_q <= 1'b0;
      else if (mie_set_i)
         mie_q <= 1'b1;
   end
endmodule

// File: rtl/irq_req_ctrl_chk.sv
module irq_req_ctrl_chk #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lp_entry_i,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               tst_i,
   input logic [IDX_W-1:0]   tst_sel_i,
   input logic               irq_o,
   input logic [IDX_W-1:0]   irq_idx_o,
   input logic               skip_o,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] flag_q,
   input logic               mie_q
);
   p_lp_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lp_entry_i |=> (en_q == '0));

   // R4 and R9: every event is visible in the flags one cycle later
   p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

   p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (mie_q && en_q[irq_idx_o] && flag_q[irq_idx_o]));

   p_irq_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (((en_q & flag_q) & ((NUM_SRC'(1) << irq_idx_o) - NUM_SRC'(1))) == '0));

   p_accept_mie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !mie_q);

   p_accept_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !evt_i[irq_idx_o]) |=> !flag_q[$past(irq_idx_o)]);

   p_skip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_o && !evt_i[tst_sel_i]) |=> !flag_q[$past(tst_sel_i)]);

   p_skip_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_i && en_q[tst_sel_i]) |-> !skip_o);

   p_skip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_i && en_q[tst_sel_i] && !(irq_o && irq_idx_o == tst_sel_i))
      |=> (flag_q[$past(tst_sel_i)] == $past(flag_q[tst_sel_i])));
endmodule

bind irq_req_ctrl irq_req_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .lp_entry_i(lp_entry_i), .evt_i(evt_i),
   .tst_i(tst_i), .tst_sel_i(tst_sel_i), .irq_o(irq_o), .irq_idx_o(irq_idx_o),
   .skip_o(skip_o), .en_q(en_vec), .flag_q(flag_vec), .mie_q(mie_q)
);

// File: tb/test_irq_req_ctrl.sv
module test_irq_req_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lp_entry_i = 1'b0;
   logic       en_wr_i = 1'b0;
   logic [0:0] en_sel_i = '0;
   logic [3:0] acc_i = '0;
   logic [3:0] en_rd_o;
   logic       mie_set_i = 1'b0;
   logic       mie_clr_i = 1'b0;
   logic [7:0] evt_i = '0;
   logic       irq_o;
   logic [2:0] irq_idx_o;
   logic       tst_i = 1'b0;
   logic [2:0] tst_sel_i = '0;
   logic       skip_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_req_ctrl i_irq_req_ctrl (.*);

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_en(input int g, input int v);
      en_wr_i = 1'b1; en_sel_i = 1'(g); acc_i = 4'(v);
      step();
      en_wr_i = 1'b0;
   endtask

   task automatic probe(input int k, output int s);
      tst_i = 1'b1; tst_sel_i = 3'(k);
      #1 s = int'(skip_o);
      step();
      tst_i = 1'b0;
   endtask

   task automatic pulse_evt(input int m);
      evt_i = 8'(m);
      step();
      evt_i = '0;
   endtask

   task automatic pulse_mie(input bit s, input bit c);
      mie_set_i = s; mie_clr_i = c;
      step();
      mie_set_i = 1'b0; mie_clr_i = 1'b0;
   endtask

   function automatic int lowest(input int m);
      for (int k = 7; k >= 0; k--) if (m[k]) lowest = k;
      if (m == 0) lowest = 0;
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int s;
      step(); step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      en_sel_i = 1'b0; #1 chk("R1 enable reg 0", en_rd_o, 0);
      en_sel_i = 1'b1; #1 chk("R1 enable reg 1", en_rd_o, 0);
      chk("R1 irq", irq_o, 0);
      for (int k = 0; k < 8; k++) begin
         probe(k, s); chk("R1 flag clear via skip", s, 0);
      end

      // R2 write and read back, both registers, all values
      for (int g = 0; g < 2; g++)
         for (int v = 0; v < 16; v++) begin
            wr_en(g, v);
            en_sel_i = 1'(g); #1 chk("R2 readback", en_rd_o, v);
         end

      // R3 low-power entry beats a write
      wr_en(0, 15); wr_en(1, 15);
      lp_entry_i = 1'b1; en_wr_i = 1'b1; en_sel_i = 1'b0; acc_i = 4'd9;
      step();
      lp_entry_i = 1'b0; en_wr_i = 1'b0;
      en_sel_i = 1'b0; #1 chk("R3 reg 0 cleared", en_rd_o, 0);
      en_sel_i = 1'b1; #1 chk("R3 reg 1 cleared", en_rd_o, 0);

      // R4, R7: flags set with everything disabled, skip consumes once
      for (int k = 0; k < 8; k++) begin
         pulse_evt(1 << k);
         #1 chk("R4 no irq while disabled", irq_o, 0);
         probe(k, s); chk("R4/R7 skip after event", s, 1);
         probe(k, s); chk("R7 flag cleared by skip", s, 0);
      end

      // R8: skip blocked while enable bit is set, flag kept
      for (int k = 0; k < 8; k++) begin
         wr_en(k / 4, 1 << (k % 4));
         pulse_evt(1 << k);
         probe(k, s); chk("R8 skip blocked", s, 0);
         wr_en(k / 4, 0);
         probe(k, s); chk("R8 flag unchanged", s, 1);
      end

      // R5, R6, R10: priority sweep over all flag patterns
      for (int p = 0; p < 256; p++) begin
         int e, pend, exp_flags;
         e = (p * 37 + 11) & 255;
         pend = p & e;
         wr_en(0, e & 15); wr_en(1, e >> 4);
         pulse_evt(p);
         #1 chk("R10 master off gates irq", irq_o, 0);
         pulse_mie(1'b1, 1'b0);
         #1 chk("R5 irq raised", irq_o, int'(pend != 0));
         if (pend != 0) chk("R5 lowest index", irq_idx_o, lowest(pend));
         step();   // acceptance edge
         exp_flags = (pend != 0) ? (p & ~(1 << lowest(pend))) : p;
         #1 chk("R6 master off after accept", irq_o, 0);
         pulse_mie(1'b0, 1'b1);
         wr_en(0, 0); wr_en(1, 0);
         for (int k = 0; k < 8; k++) begin
            probe(k, s); chk("R6 remaining flags", s, (exp_flags >> k) & 1);
         end
      end

      // R9: event and skip clear in the same cycle
      pulse_evt(1 << 3);
      evt_i = 8'(1 << 3); tst_i = 1'b1; tst_sel_i = 3'd3;
      #1 chk("R9 skip seen", skip_o, 1);
      step();
      evt_i = '0; tst_i = 1'b0;
      probe(3, s); chk("R9 set beats skip clear", s, 1);
      probe(3, s); chk("R9 cleared afterwards", s, 0);

      // R9: event and acceptance clear in the same cycle
      wr_en(1, 2);
      pulse_evt(1 << 5);
      pulse_mie(1'b1, 1'b0);
      #1 chk("R9 irq up", irq_o, 1);
      chk("R9 irq index 5", irq_idx_o, 5);
      evt_i = 8'(1 << 5);
      step();
      evt_i = '0;
      #1 chk("R9 master off after accept", irq_o, 0);
      wr_en(1, 0);
      probe(5, s); chk("R9 set beats accept clear", s, 1);

      // R10: clear beats set
      wr_en(0, 1);
      pulse_evt(1);
      pulse_mie(1'b1, 1'b1);
      #1 chk("R10 clear wins", irq_o, 0);
      pulse_mie(1'b1, 1'b0);
      #1 chk("R10 set alone enables", irq_o, 1);
      chk("R10 index 0", irq_idx_o, 0);
      step();
      wr_en(0, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule